// File: doc/BRIEF.md
# Calibration and Nonvolatile-Operation Sequencer

This block sits beside a configurable analog core. It accepts start requests for three timed operations: offset calibration, programming of a configuration image, and bulk erase of a configuration image. It then runs the accepted operation for its full interval. While an operation runs, `busy_o` is high. For calibration and erase, the block also tells the analog side to park its outputs at the reference level. During erase it also tells the analog side to disconnect its inputs. The calibration algorithm itself is not part of the block; `cal_done_o` only reports that a calibration interval has finished.

There are four start sources:
- power-on reset, which always begins a long calibration;
- a rising edge on an external calibration pin;
- a calibration command from the test-access-port controller;
- program and erase commands from the same controller.

All intervals are counted in ticks. A tick comes from a parameterised prescaler on the system clock. Two image registers model the nonvolatile store. A program operation can only set bits, so a 1 can never return to 0 except through an erase.

Top module: `trim_nv_sequencer`

## Requirements
- R1: While reset is low, and for CAL_PWR_TICKS*PRESCALE cycles after it is released, `busy_o` and `hold_ref_o` are 1 and `op_o` is 1 (calibration). Both images read 0 after reset.
- R2: A rising edge on `cal_pin_i` while idle starts a user calibration. `busy_o` rises after the third clock edge following the pin's rise, and stays high for CAL_USR_TICKS*PRESCALE cycles. A pin pulse one clock period wide is enough.
- R3: While idle, `tap_cal_i` high at a clock edge starts a user calibration of the same length. The level of `tap_cal_i` after that edge does not change the running interval.
- R4: A program request (`op_o`=2) or an erase request (`op_o`=3) keeps `busy_o` high for NV_TICKS*PRESCALE cycles. `busy_o` rises one edge after the request.
- R5: When a program operation ends, the image chosen by `img_sel_i` (0 selects image A, 1 selects image B) becomes its old value OR the data on `prog_data_i`. Both the select and the data are captured at the edge that accepts the request. The other image is unchanged, and no image ever loses a 1 bit except through an erase.
- R6: When an erase operation ends, the selected image becomes all zeros. Images never change while the block is idle.
- R7: `hold_ref_o` is 1 during calibration and erase and 0 during program and idle. `in_iso_o` is 1 only during erase.
- R8: Any request that arrives while an operation runs is dropped and not kept for later. This includes pin edges seen during the power-up calibration.
- R9: If several requests arrive together while idle, the winner is chosen in this order: erase, then program, then TAP calibration, then pin calibration.
- R10: `cal_done_o` is high for exactly the one cycle after any calibration ends. It is never high after a program or an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cal_pin_i | input | 1 | Asynchronous calibration pin; a rising edge requests calibration |
| tap_cal_i | input | 1 | Calibration command from the TAP controller |
| tap_prog_i | input | 1 | Program command from the TAP controller |
| tap_erase_i | input | 1 | Bulk-erase command from the TAP controller |
| img_sel_i | input | 1 | Target image of a program or erase: 0 selects A, 1 selects B |
| prog_data_i | input | IMG_W | Data to be ORed into the target image |
| busy_o | output | 1 | An operation is running |
| op_o | output | 2 | Running operation: 0 idle, 1 calibration, 2 program, 3 erase |
| hold_ref_o | output | 1 | Force the analog outputs to the reference level |
| in_iso_o | output | 1 | Disconnect the analog inputs |
| cal_done_o | output | 1 | One-cycle pulse after a calibration ends |
| img_a_o | output | IMG_W | Configuration image A |
| img_b_o | output | IMG_W | Configuration image B |

## Verification
The program path is driven with data patterns that overlap the stored bits, that add only new bits, that are all zeros, and that fill the image completely. These patterns separate a true OR update from a plain overwrite and from a clear.

Erases alternate between the two images. This exposes a select that has been swapped or ignored.

Every operation kind has its interval measured in cycles. This distinguishes the power-up calibration length from the user calibration length and from the program/erase length.

Requests are also injected during a running operation, and several sources are fired in the same cycle. These tests show whether a request was dropped, queued, or wrongly given priority.

// File: rtl/trim_seq_pkg.sv
`timescale 1ns/1ps
package trim_seq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CAL   = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cal_pin_edge.sv
`timescale 1ns/1ps
module cal_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  // last synchronized sample vs. the one before it
  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/op_timer.sv
`timescale 1ns/1ps
module op_timer #(
  parameter int PRESCALE = 125000,
  parameter int TICK_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [TICK_W-1:0] dur_i,
  output logic              done_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic              tick;
  logic [TICK_W-1:0] tcnt_q;

  generate
    if (PRESCALE == 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (start_i) pre_q <= '0;
        else if (run_i)   pre_q <= tick ? '0 : pre_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tcnt_q <= '0;
    else if (start_i)         tcnt_q <= '0;
    else if (run_i && tick)   tcnt_q <= tcnt_q + 1'b1;
  end

  assign done_o = run_i && tick && (tcnt_q == dur_i - TICK_W'(1));
endmodule

// File: rtl/image_bank.sv
`timescale 1ns/1ps
module image_bank #(
  parameter int IMG_W = 16,
  parameter int N_IMG = 2,
  localparam int SEL_W = (N_IMG > 1) ? $clog2(N_IMG) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  input  logic                        erase_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [IMG_W-1:0]            data_i,
  output logic [N_IMG-1:0][IMG_W-1:0] img_o
);
  generate
    for (genvar g = 0; g < N_IMG; g++) begin : g_img
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          img_o[g] <= '0;
        end else if (commit_i && sel_i == SEL_W'(g)) begin
          // cells can only be set by program; only erase clears
          img_o[g] <= erase_i ? '0 : (img_o[g] | data_i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/trim_nv_sequencer.sv
`timescale 1ns/1ps
module trim_nv_sequencer
  import trim_seq_pkg::*;
#(
  parameter int IMG_W         = 16,
  parameter int PRESCALE      = 125000,
  parameter int CAL_PWR_TICKS = 250,
  parameter int CAL_USR_TICKS = 100,
  parameter int NV_TICKS      = 90,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_pin_i,
  input  logic             tap_cal_i,
  input  logic             tap_prog_i,
  input  logic             tap_erase_i,
  input  logic             img_sel_i,
  input  logic [IMG_W-1:0] prog_data_i,
  output logic             busy_o,
  output logic [1:0]       op_o,
  output logic             hold_ref_o,
  output logic             in_iso_o,
  output logic             cal_done_o,
  output logic [IMG_W-1:0] img_a_o,
  output logic [IMG_W-1:0] img_b_o
);
  localparam int MAX_TICKS = max3(CAL_PWR_TICKS, CAL_USR_TICKS, NV_TICKS);
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  op_e               op_q, req_op;
  logic [TICK_W-1:0] dur_q, req_dur;
  logic              sel_q;
  logic [IMG_W-1:0]  data_q;
  logic              cal_done_q;
  logic              idle, accept, done, pin_rise;
  logic [1:0][IMG_W-1:0] imgs;

  cal_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cal_pin_i),
    .rise_o (pin_rise)
  );

  assign idle = (op_q == OP_IDLE);

  always_comb begin
    req_op  = OP_IDLE;
    req_dur = TICK_W'(CAL_USR_TICKS);
    if (tap_erase_i) begin
      req_op  = OP_ERASE;
      req_dur = TICK_W'(NV_TICKS);
    end else if (tap_prog_i) begin
      req_op  = OP_PROG;
      req_dur = TICK_W'(NV_TICKS);
    end else if (tap_cal_i || pin_rise) begin
      req_op  = OP_CAL;
      req_dur = TICK_W'(CAL_USR_TICKS);
    end
  end

  assign accept = idle && (req_op != OP_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_CAL;
      dur_q      <= TICK_W'(CAL_PWR_TICKS);
      sel_q      <= 1'b0;
      data_q     <= '0;
      cal_done_q <= 1'b0;
    end else begin
      cal_done_q <= done && (op_q == OP_CAL);
      if (accept) begin
        op_q   <= req_op;
        dur_q  <= req_dur;
        sel_q  <= img_sel_i;
        data_q <= prog_data_i;
      end else if (done) begin
        op_q <= OP_IDLE;
      end
    end
  end

  op_timer #(.PRESCALE(PRESCALE), .TICK_W(TICK_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .run_i   (!idle),
    .dur_i   (dur_q),
    .done_o  (done)
  );

  image_bank #(.IMG_W(IMG_W), .N_IMG(2)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (done && (op_q == OP_PROG || op_q == OP_ERASE)),
    .erase_i  (op_q == OP_ERASE),
    .sel_i    (sel_q),
    .data_i   (data_q),
    .img_o    (imgs)
  );

  assign busy_o     = !idle;
  assign op_o       = op_q;
  assign hold_ref_o = (op_q == OP_CAL) || (op_q == OP_ERASE);
  assign in_iso_o   = (op_q == OP_ERASE);
  assign cal_done_o = cal_done_q;
  assign img_a_o    = imgs[0];
  assign img_b_o    = imgs[1];
endmodule

// File: rtl/trim_nv_sequencer_chk.sv
`timescale 1ns/1ps
module trim_nv_sequencer_chk #(
  parameter int IMG_W         = 16,
  parameter int PRESCALE      = 125000,
  parameter int CAL_PWR_TICKS = 250,
  parameter int CAL_USR_TICKS = 100,
  parameter int NV_TICKS      = 90
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic [1:0]       op_o,
  input logic             hold_ref_o,
  input logic             in_iso_o,
  input logic             cal_done_o,
  input logic [IMG_W-1:0] img_a_o,
  input logic [IMG_W-1:0] img_b_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else         busy_cnt <= busy_o ? busy_cnt + 1 : 0;
  end

  a_r4_nv_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && ($past(op_o) == 2'd2 || $past(op_o) == 2'd3))
      |-> busy_cnt == NV_TICKS * PRESCALE);

  a_r2_cal_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(op_o) == 2'd1)
      |-> (busy_cnt == CAL_USR_TICKS * PRESCALE || busy_cnt == CAL_PWR_TICKS * PRESCALE));

  a_r8_no_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o != 2'd0) |=> (op_o == $past(op_o) || op_o == 2'd0));

  a_r5_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o != 2'd3) |=> (((img_a_o & $past(img_a_o)) == $past(img_a_o)) &&
                        ((img_b_o & $past(img_b_o)) == $past(img_b_o))));

  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 2'd0) |=> ($stable(img_a_o) && $stable(img_b_o)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 2'd1 || op_o == 2'd3) |-> (hold_ref_o && busy_o));

  a_r7_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_iso_o |-> (op_o == 2'd3 && hold_ref_o));

  a_r10_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> (!busy_o && $past(op_o) == 2'd1));
endmodule

bind trim_nv_sequencer trim_nv_sequencer_chk #(
  .IMG_W(IMG_W), .PRESCALE(PRESCALE), .CAL_PWR_TICKS(CAL_PWR_TICKS),
  .CAL_USR_TICKS(CAL_USR_TICKS), .NV_TICKS(NV_TICKS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .op_o(op_o),
  .hold_ref_o(hold_ref_o), .in_iso_o(in_iso_o), .cal_done_o(cal_done_o),
  .img_a_o(img_a_o), .img_b_o(img_b_o)
);

// File: tb/trim_nv_sequencer_bench.sv
`timescale 1ns/1ps
module trim_nv_sequencer_bench;
  localparam int P   = 3;
  localparam int PWR = 6;
  localparam int USR = 4;
  localparam int NV  = 5;
  localparam int W   = 8;

  // {kind[1:0], sel, data[7:0], exp_a[7:0], exp_b[7:0]}; kind 0 prog,1 erase,2 tap cal,3 pin cal
  localparam logic [26:0] VEC [12] = '{
    {2'd0, 1'b0, 8'h35, 8'h35, 8'h00},
    {2'd0, 1'b1, 8'hC2, 8'h35, 8'hC2},
    {2'd0, 1'b0, 8'h4A, 8'h7F, 8'hC2},
    {2'd3, 1'b0, 8'h00, 8'h7F, 8'hC2},
    {2'd0, 1'b0, 8'h80, 8'hFF, 8'hC2},
    {2'd1, 1'b1, 8'h00, 8'hFF, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'hFF, 8'h00},
    {2'd0, 1'b1, 8'h0F, 8'hFF, 8'h0F},
    {2'd1, 1'b0, 8'h00, 8'h00, 8'h0F},
    {2'd0, 1'b0, 8'h00, 8'h00, 8'h0F},
    {2'd0, 1'b0, 8'hA5, 8'hA5, 8'h0F},
    {2'd3, 1'b1, 8'h00, 8'hA5, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_pin = 1'b0, tap_cal = 1'b0, tap_prog = 1'b0, tap_erase = 1'b0, img_sel = 1'b0;
  logic [W-1:0] prog_data = '0;
  logic busy, hold_ref, in_iso, cal_done;
  logic [1:0] op;
  logic [W-1:0] img_a, img_b;
  int nchk = 0, nfail = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  trim_nv_sequencer #(
    .IMG_W(W), .PRESCALE(P), .CAL_PWR_TICKS(PWR), .CAL_USR_TICKS(USR), .NV_TICKS(NV)
  ) u_trim_nv_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cal_pin_i(cal_pin), .tap_cal_i(tap_cal),
    .tap_prog_i(tap_prog), .tap_erase_i(tap_erase), .img_sel_i(img_sel),
    .prog_data_i(prog_data), .busy_o(busy), .op_o(op), .hold_ref_o(hold_ref),
    .in_iso_o(in_iso), .cal_done_o(cal_done), .img_a_o(img_a), .img_b_o(img_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fire(input logic e, input logic p, input logic c, input logic pin,
                      input logic sel, input logic [W-1:0] d);
    tap_erase = e; tap_prog = p; tap_cal = c; cal_pin = pin; img_sel = sel; prog_data = d;
    @(negedge clk);
    tap_erase = 0; tap_prog = 0; tap_cal = 0; cal_pin = 0; prog_data = ~d; img_sel = ~sel;
  endtask

  task automatic quiet(input string req, input int cycles);
    bit any = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (busy) any = 1;
    end
    chk(!any, req, any, 0);
  endtask

  task automatic run_op(input logic [26:0] v);
    logic [1:0] kind;
    logic [1:0] eop;
    int edur, n;
    string dreq;
    kind = v[26:25];
    fire(kind == 1, kind == 0, kind == 2, kind == 3, v[24], v[23:16]);
    if (kind == 3) begin
      chk(!busy, "R2", busy, 0);
      @(negedge clk);
      chk(!busy, "R2", busy, 0);
      @(negedge clk);
    end
    case (kind)
      2'd0: begin eop = 2'd2; edur = NV * P;  dreq = "R4"; end
      2'd1: begin eop = 2'd3; edur = NV * P;  dreq = "R4"; end
      2'd2: begin eop = 2'd1; edur = USR * P; dreq = "R3"; end
      default: begin eop = 2'd1; edur = USR * P; dreq = "R2"; end
    endcase
    chk(op == eop, dreq, op, eop);
    chk(hold_ref == (kind != 0), "R7", hold_ref, kind != 0);
    chk(in_iso == (kind == 1), "R7", in_iso, kind == 1);
    count_busy(n);
    chk(n == edur, dreq, n, edur);
    chk(cal_done == (kind >= 2), "R10", cal_done, kind >= 2);
    chk(img_a == v[15:8], (kind == 1) ? "R6" : "R5", img_a, v[15:8]);
    chk(img_b == v[7:0],  (kind == 1) ? "R6" : "R5", img_b, v[7:0]);
    @(negedge clk);
    chk(cal_done == 0, "R10", cal_done, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    cal_pin = 1'b1;  // held high through reset: edge must be lost in power-up cal (R8)
    repeat (3) @(negedge clk);
    chk(busy && hold_ref, "R1", {busy, hold_ref}, 3);
    chk(op == 2'd1, "R1", op, 1);
    chk(img_a == 0 && img_b == 0, "R1", {img_a, img_b}, 0);
    rst_n = 1'b1;
    count_busy(n);
    chk(n == PWR * P, "R1", n, PWR * P);
    chk(cal_done == 1, "R10", cal_done, 1);
    quiet("R8", 5);
    cal_pin = 1'b0;
    quiet("R8", 4);

    for (int i = 0; i < 12; i++) run_op(VEC[i]);

    // R8: requests during a program are dropped
    fire(0, 1, 0, 0, 0, 8'h02);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (n == 3) begin tap_erase = 1; tap_cal = 1; cal_pin = 1; img_sel = 0; end
      if (n == 4) begin tap_erase = 0; tap_cal = 0; cal_pin = 0; end
      @(negedge clk);
    end
    chk(n == NV * P, "R8", n, NV * P);
    chk(img_a == 8'hA7, "R8", img_a, 8'hA7);
    quiet("R8", 4);

    // R3: TAP level after acceptance does not alter the interval
    fire(0, 0, 1, 0, 0, 8'h00);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      tap_cal = (n >= 2 && n < 6) || (n == 8);
      @(negedge clk);
    end
    tap_cal = 0;
    chk(n == USR * P, "R3", n, USR * P);
    quiet("R3", 3);

    // R9: erase beats program
    fire(1, 1, 1, 0, 1, 8'hFF);
    chk(op == 2'd3, "R9", op, 3);
    count_busy(n);
    chk(img_b == 8'h00, "R9", img_b, 0);
    chk(img_a == 8'hA7, "R9", img_a, 8'hA7);
    @(negedge clk);
    // R9: program beats TAP calibration
    fire(0, 1, 1, 1, 1, 8'h3C);
    chk(op == 2'd2, "R9", op, 2);
    count_busy(n);
    chk(img_b == 8'h3C, "R9", img_b, 8'h3C);
    chk(cal_done == 0, "R10", cal_done, 0);
    quiet("R8", 4);
    // R9: TAP and pin together give one calibration only
    fire(0, 0, 1, 1, 0, 8'h00);
    chk(op == 2'd1, "R9", op, 1);
    count_busy(n);
    chk(n == USR * P, "R9", n, USR * P);
    quiet("R9", 5);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule